// File: doc/BRIEF.md
# Configuration Register Bank with Sticky Status

This block is a small register file that sits behind a two-wire serial slave. The bit-level serial protocol is outside it. Each access arrives as a byte-level read or write strobe that carries a 7-bit device address, a register index and a data byte. Three things reach the block only through its ports: a core-voltage offset setting, a read-only load-current indication, and a revision byte. A miscellaneous register holds the enable for a periodic watchdog reset generator. It also holds two status flags that stay set until software clears them. A flag records that the socket-occupied input was asserted, or that a watchdog reset pulse was issued. Software clears a flag only by writing 0 to its bit.

The bank has two reset sources besides the chip reset. The socket-occupied input returns every register to its default. A watchdog pulse returns the offset and current registers to default but spares the miscellaneous register. The generator drives its pulse out as an active-low reset. The offset code is exported as a raw 5-bit value and also as a decoded millivolt value for downstream logic.

Top module: `cfg_regbank`

## Requirements
- R1: An access is acknowledged only when `bus_dev_i` equals 7'h2F with `addr_sel_i`=1, or 7'h2E with `addr_sel_i`=0. These are the byte forms 0x5E and 0x5C. An access to any other device address has no effect and gets no acknowledge.
- R2: After reset the registers hold these values: index 0x00 reads 0x00, index 0x01 reads 0x00, index 0x03 reads 0x04. `wd_rst_n_o` is 1.
- R3: A write to index 0x00 stores data bits 4:0 as the offset code. The code drives `offs_code_o`, and index 0x00 reads back as {3'b000, code}.
- R4: `offs_mv_o` is 25 times the code for codes 0 to 30 and 800 for code 31.
- R5: Index 0x01 reads {1'b0, `curr_i` as sampled at the previous clock edge}. Writes to it are ignored.
- R6: Index 0x03 reads {5'b0, socket flag at bit 2, watchdog flag at bit 1, enable at bit 0}. Writing 0 to bit 2 or bit 1 clears that flag, and writing 1 to either leaves it unchanged.
- R7: Bit 0 of index 0x03 is read/write. While it is 1, `wd_rst_n_o` repeats a cycle of 28 high cycles followed by 4 low cycles. The first high phase starts at the write. While bit 0 is 0, `wd_rst_n_o` stays 1.
- R8: Each watchdog pulse returns indices 0x00 and 0x01 to 0x00 and sets bit 1 of index 0x03. Bits 2 and 0 of index 0x03 are unchanged.
- R9: A clock edge with `socket_i`=1 returns every register, index 0x03 included, to its R2 value. This also stops the generator.
- R10: Index 0x13 reads 0x00 (the revision). Unimplemented indices read 0x00. Writes to 0x13 and to unimplemented indices change nothing.
- R11: `bus_ack_o` and `bus_rdata_o` are valid in the cycle after the strobe's clock edge. A write returns data 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_sel_i | input | 1 | Device address select |
| socket_i | input | 1 | Socket-occupied input; 1 resets the whole bank |
| bus_dev_i | input | 7 | Device address of the access |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_reg_i | input | 8 | Register index |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, one cycle after the strobe |
| bus_ack_o | output | 1 | Access acknowledge, one cycle after the strobe |
| curr_i | input | 7 | Measured load current code |
| offs_code_o | output | 5 | Offset code |
| offs_mv_o | output | 10 | Decoded offset in millivolts |
| wd_rst_n_o | output | 1 | Watchdog reset pulse, active low |

## Verification
The hardest state to reach from the ports is a watchdog pulse that lands on a partly populated bank. In that state the offset must be cleared while the enable and the socket flag survive and the watchdog flag is newly set. The stimulus first uses a socket pulse to set the socket flag. It then rewrites the miscellaneous register so that the enable is on and the socket flag is kept, and loads a nonzero offset. Next it waits on the output pulse, whose high and low phases it measures in cycles against the required lengths. Finally it reads back every register through the bus. A separate sequence writes 1 and then 0 to each status flag to show that neither can be set by a write.

// File: rtl/cfg_regbank_pkg.sv
package cfg_regbank_pkg;
  localparam int DEV_W  = 7;
  localparam int IDX_W  = 8;
  localparam int DATA_W = 8;
  localparam int OFFS_W = 5;
  localparam int CURR_W = 7;
  localparam int MV_W   = 10;

  localparam logic [IDX_W-1:0] IDX_OFFS = 8'h00;
  localparam logic [IDX_W-1:0] IDX_CURR = 8'h01;
  localparam logic [IDX_W-1:0] IDX_MISC = 8'h03;
  localparam logic [IDX_W-1:0] IDX_REV  = 8'h13;

  // status flags in the miscellaneous register: [0] watchdog seen, [1] socket seen
  localparam int             STICKY_N   = 2;
  localparam int             STICKY_LSB = 1;
  localparam logic [STICKY_N-1:0] STICKY_DEF = 2'b10;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/cfg_addr_match.sv
module cfg_addr_match #(
  parameter int             DEV_W  = 7,
  parameter logic [DEV_W-1:0] ADDR_HI = 7'h2F,
  parameter logic [DEV_W-1:0] ADDR_LO = 7'h2E
) (
  input  logic             sel_i,
  input  logic [DEV_W-1:0] dev_i,
  output logic             hit_o
);
  logic [DEV_W-1:0] own_addr;

  always_comb begin
    own_addr = sel_i ? ADDR_HI : ADDR_LO;
    hit_o    = (dev_i == own_addr);
  end
endmodule

// File: rtl/cfg_wdog_gen.sv
module cfg_wdog_gen #(
  parameter int PULSE_CYC = 4,
  parameter int WAIT_MULT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic pulse_o
);
  localparam int WAIT_CYC = PULSE_CYC * WAIT_MULT;
  localparam int CNT_W    = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

  logic             low_q, low_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    low_d = low_q;
    cnt_d = cnt_q;
    if (clr_i || !en_i) begin
      low_d = 1'b0;
      cnt_d = '0;
    end else if (!low_q) begin
      if (cnt_q == CNT_W'(WAIT_CYC - 1)) begin
        low_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == CNT_W'(PULSE_CYC - 1)) begin
        low_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      low_q <= low_d;
      cnt_q <= cnt_d;
    end
  end

  assign pulse_o = low_q;
endmodule

// File: rtl/cfg_offs_decode.sv
module cfg_offs_decode #(
  parameter int OFFS_W  = 5,
  parameter int MV_W    = 10,
  parameter int STEP_MV = 25,
  parameter int TOP_MV  = 800
) (
  input  logic [OFFS_W-1:0] code_i,
  output logic [MV_W-1:0]   mv_o
);
  always_comb begin
    if (&code_i) mv_o = MV_W'(TOP_MV);
    else         mv_o = MV_W'(STEP_MV * int'(code_i));
  end
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_regbank_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_HI  = 7'h2F,
  parameter logic [6:0] DEV_ADDR_LO  = 7'h2E,
  parameter logic [7:0] REV_ID       = 8'h00,
  parameter int         WD_PULSE_CYC = 4,
  parameter int         WD_WAIT_MULT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel_i,
  input  logic              socket_i,
  input  logic [DEV_W-1:0]  bus_dev_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [IDX_W-1:0]  bus_reg_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_ack_o,
  input  logic [CURR_W-1:0] curr_i,
  output logic [OFFS_W-1:0] offs_code_o,
  output logic [MV_W-1:0]   offs_mv_o,
  output logic              wd_rst_n_o
);
  logic rst_n_sync;
  logic dev_hit, wd_pulse;
  logic wr_offs, wr_misc, bank_clr;
  logic unused_wdata_hi;

  logic [OFFS_W-1:0]   offs_q, offs_d;
  logic                offs_en;
  logic [CURR_W-1:0]   curr_q, curr_d;
  logic                wd_en_q, wd_en_d, wd_en_en;
  logic [STICKY_N-1:0] sticky_q, sticky_d, sticky_set;
  logic [DATA_W-1:0]   rdata_q, rdata_d, rd_mux;
  logic                ack_q, ack_d;

  cfg_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_sync)
  );

  cfg_addr_match #(
    .DEV_W   (DEV_W),
    .ADDR_HI (DEV_ADDR_HI),
    .ADDR_LO (DEV_ADDR_LO)
  ) u_match (
    .sel_i (addr_sel_i),
    .dev_i (bus_dev_i),
    .hit_o (dev_hit)
  );

  cfg_wdog_gen #(
    .PULSE_CYC (WD_PULSE_CYC),
    .WAIT_MULT (WD_WAIT_MULT)
  ) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .clr_i   (socket_i),
    .en_i    (wd_en_q),
    .pulse_o (wd_pulse)
  );

  cfg_offs_decode #(
    .OFFS_W (OFFS_W),
    .MV_W   (MV_W)
  ) u_decode (
    .code_i (offs_q),
    .mv_o   (offs_mv_o)
  );

  assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:OFFS_W];

  // access decode
  always_comb begin
    wr_offs  = bus_wr_i && dev_hit && (bus_reg_i == IDX_OFFS);
    wr_misc  = bus_wr_i && dev_hit && (bus_reg_i == IDX_MISC);
    bank_clr = socket_i || wd_pulse;
  end

  // offset and current registers: cleared by either reset source
  always_comb begin
    offs_en = bank_clr || wr_offs;
    offs_d  = bank_clr ? '0 : bus_wdata_i[OFFS_W-1:0];
    curr_d  = bank_clr ? '0 : curr_i;
  end

  // enable bit: only the socket reset touches it
  always_comb begin
    wd_en_en = socket_i || wr_misc;
    wd_en_d  = socket_i ? 1'b0 : bus_wdata_i[0];
  end

  // status flags: set by their event, cleared only by a written 0
  assign sticky_set = {socket_i, wd_pulse};

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    assign sticky_d[i] = socket_i      ? STICKY_DEF[i] :
                         sticky_set[i] ? 1'b1 :
                         wr_misc       ? (sticky_q[i] & bus_wdata_i[STICKY_LSB+i]) :
                                         sticky_q[i];
  end

  // read path
  always_comb begin
    case (bus_reg_i)
      IDX_OFFS: rd_mux = {{(DATA_W-OFFS_W){1'b0}}, offs_q};
      IDX_CURR: rd_mux = {{(DATA_W-CURR_W){1'b0}}, curr_q};
      IDX_MISC: rd_mux = {{(DATA_W-STICKY_N-1){1'b0}}, sticky_q, wd_en_q};
      IDX_REV:  rd_mux = REV_ID;
      default:  rd_mux = '0;
    endcase
    ack_d   = (bus_rd_i || bus_wr_i) && dev_hit;
    rdata_d = (bus_rd_i && dev_hit) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      offs_q   <= '0;
      curr_q   <= '0;
      wd_en_q  <= 1'b0;
      sticky_q <= STICKY_DEF;
      rdata_q  <= '0;
      ack_q    <= 1'b0;
    end else begin
      if (offs_en)  offs_q  <= offs_d;
      if (wd_en_en) wd_en_q <= wd_en_d;
      curr_q   <= curr_d;
      sticky_q <= sticky_d;
      rdata_q  <= rdata_d;
      ack_q    <= ack_d;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign bus_ack_o   = ack_q;
  assign offs_code_o = offs_q;
  assign wd_rst_n_o  = ~wd_pulse;
endmodule

// File: rtl/cfg_regbank_chk.sv
module cfg_regbank_chk #(
  parameter logic [6:0] ADDR_HI = 7'h2F,
  parameter logic [6:0] ADDR_LO = 7'h2E
) (
  input logic       clk,
  input logic       rst_n_sync,
  input logic       addr_sel_i,
  input logic       socket_i,
  input logic [6:0] bus_dev_i,
  input logic       bus_wr_i,
  input logic       bus_rd_i,
  input logic       bus_ack_o,
  input logic [4:0] offs_code_o,
  input logic [9:0] offs_mv_o,
  input logic       wd_rst_n_o,
  input logic       wd_en_q
);
  // R1: a foreign device address never draws an acknowledge
  p_no_ack_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((bus_rd_i || bus_wr_i) && (bus_dev_i != (addr_sel_i ? ADDR_HI : ADDR_LO)))
      |=> !bus_ack_o);

  // R11: acknowledge only follows a strobe
  p_ack_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    bus_ack_o |-> $past(bus_rd_i || bus_wr_i));

  // R9: socket reset clears the offset and quiets the generator
  p_socket_clears_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    socket_i |=> (offs_code_o == 5'd0) && wd_rst_n_o);

  // R8: a watchdog pulse clears the offset
  p_wd_clears_offs_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !wd_rst_n_o |=> (offs_code_o == 5'd0));

  // R7: no pulse while disabled
  p_wd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !wd_en_q |=> wd_rst_n_o);

  // R4: decoded value never exceeds the top of the range
  p_mv_bound_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    offs_mv_o <= 10'd800);
endmodule

bind cfg_regbank cfg_regbank_chk #(
  .ADDR_HI (DEV_ADDR_HI),
  .ADDR_LO (DEV_ADDR_LO)
) u_chk (
  .clk         (clk),
  .rst_n_sync  (rst_n_sync),
  .addr_sel_i  (addr_sel_i),
  .socket_i    (socket_i),
  .bus_dev_i   (bus_dev_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_ack_o   (bus_ack_o),
  .offs_code_o (offs_code_o),
  .offs_mv_o   (offs_mv_o),
  .wd_rst_n_o  (wd_rst_n_o),
  .wd_en_q     (wd_en_q)
);

// File: tb/cfg_regbank_test.sv
module cfg_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 28;
  localparam int PULSE_CYC  = 4;
  localparam logic [6:0] CURR_VAL = 7'h35;

  logic       clk = 1'b0;
  logic       rst_n, addr_sel_i, socket_i, bus_wr_i, bus_rd_i;
  logic [6:0] bus_dev_i, curr_i;
  logic [7:0] bus_reg_i, bus_wdata_i, bus_rdata_o;
  logic       bus_ack_o, wd_rst_n_o;
  logic [4:0] offs_code_o;
  logic [9:0] offs_mv_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_regbank uut (
    .clk(clk), .rst_n(rst_n), .addr_sel_i(addr_sel_i), .socket_i(socket_i),
    .bus_dev_i(bus_dev_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_reg_i(bus_reg_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .bus_ack_o(bus_ack_o), .curr_i(curr_i), .offs_code_o(offs_code_o),
    .offs_mv_o(offs_mv_o), .wd_rst_n_o(wd_rst_n_o)
  );

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [6:0] dev;
    logic [7:0] idx;
    logic [7:0] wdat;
    logic       ack;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 23;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b1,7'h2E,8'h00,8'h00,1'b1,8'h00,4'd2 },  // R2 offset default
    '{1'b0,1'b1,7'h2E,8'h01,8'h00,1'b1,8'h35,4'd5 },  // R5 current sample
    '{1'b0,1'b1,7'h2E,8'h03,8'h00,1'b1,8'h04,4'd2 },  // R2 misc default
    '{1'b1,1'b0,7'h2E,8'h00,8'h13,1'b1,8'h00,4'd11},  // R11 write returns 0
    '{1'b0,1'b1,7'h2E,8'h00,8'h00,1'b1,8'h13,4'd3 },  // R3
    '{1'b1,1'b0,7'h2E,8'h00,8'hFF,1'b1,8'h00,4'd3 },
    '{1'b0,1'b1,7'h2E,8'h00,8'h00,1'b1,8'h1F,4'd3 },  // R3 upper bits dropped
    '{1'b1,1'b0,7'h2F,8'h00,8'h05,1'b0,8'h00,4'd1 },  // R1 foreign address
    '{1'b0,1'b1,7'h2E,8'h00,8'h00,1'b1,8'h1F,4'd1 },  // R1 no change
    '{1'b1,1'b0,7'h2E,8'h01,8'h7F,1'b1,8'h00,4'd5 },
    '{1'b0,1'b1,7'h2E,8'h01,8'h00,1'b1,8'h35,4'd5 },  // R5 write ignored
    '{1'b1,1'b0,7'h2E,8'h03,8'hFE,1'b1,8'h00,4'd6 },
    '{1'b0,1'b1,7'h2E,8'h03,8'h00,1'b1,8'h04,4'd6 },  // R6 ones keep flags
    '{1'b1,1'b0,7'h2E,8'h03,8'h00,1'b1,8'h00,4'd6 },
    '{1'b0,1'b1,7'h2E,8'h03,8'h00,1'b1,8'h00,4'd6 },  // R6 zero clears
    '{1'b1,1'b0,7'h2E,8'h03,8'h04,1'b1,8'h00,4'd6 },
    '{1'b0,1'b1,7'h2E,8'h03,8'h00,1'b1,8'h00,4'd6 },  // R6 cannot set
    '{1'b0,1'b1,7'h2E,8'h13,8'h00,1'b1,8'h00,4'd10},  // R10 revision
    '{1'b1,1'b0,7'h2E,8'h02,8'hAA,1'b1,8'h00,4'd10},
    '{1'b0,1'b1,7'h2E,8'h02,8'h00,1'b1,8'h00,4'd10},  // R10 hole reads 0
    '{1'b0,1'b1,7'h2F,8'h00,8'h00,1'b0,8'h00,4'd1 },  // R1 foreign read
    '{1'b1,1'b0,7'h2E,8'h13,8'h55,1'b1,8'h00,4'd10},
    '{1'b0,1'b1,7'h2E,8'h13,8'h00,1'b1,8'h00,4'd10}   // R10 revision unchanged
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic w, input logic r, input logic [6:0] dev,
                        input logic [7:0] idx, input logic [7:0] wdat,
                        output logic ack, output logic [7:0] rdat);
    @(negedge clk);
    bus_wr_i = w; bus_rd_i = r; bus_dev_i = dev; bus_reg_i = idx; bus_wdata_i = wdat;
    @(negedge clk);
    ack  = bus_ack_o;
    rdat = bus_rdata_o;
    bus_wr_i = 1'b0; bus_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    logic a; logic [7:0] r;
    bus_op(1'b1, 1'b0, addr_sel_i ? 7'h2F : 7'h2E, idx, d, a, r);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] idx, input logic [7:0] exp);
    logic a; logic [7:0] r;
    bus_op(1'b0, 1'b1, addr_sel_i ? 7'h2F : 7'h2E, idx, 8'h00, a, r);
    check(tag, {7'd0, a, r}, {7'd0, 1'b1, exp});
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int hi_n, lo_n;
    logic a;
    logic [7:0] r;
    rst_n = 1'b0; addr_sel_i = 1'b0; socket_i = 1'b0;
    bus_wr_i = 1'b0; bus_rd_i = 1'b0; bus_dev_i = '0; bus_reg_i = '0;
    bus_wdata_i = '0; curr_i = CURR_VAL;
    do_reset();

    // R2: outputs after reset
    check("R2 offs_code", 16'(offs_code_o), 16'd0);
    check("R2 offs_mv",   16'(offs_mv_o),   16'd0);
    check("R2 wd_rst_n",  16'(wd_rst_n_o),  16'd1);

    for (int i = 0; i < NVEC; i++) begin
      bus_op(VEC[i].wr, VEC[i].rd, VEC[i].dev, VEC[i].idx, VEC[i].wdat, a, r);
      n_cmp++;
      if (a !== VEC[i].ack || r !== VEC[i].exp) begin
        n_bad++;
        $display("FAIL R%0d vec %0d: actual ack=%0b data=%0h expected ack=%0b data=%0h",
                 VEC[i].req, i, a, r, VEC[i].ack, VEC[i].exp);
      end
    end

    // R4: code 31 maps to 800, the rest to 25 mV steps
    check("R4 code31", 16'(offs_mv_o), 16'd800);
    for (int c = 0; c < 32; c++) begin
      wr(8'h00, 8'(c));
      check("R4 decode", 16'(offs_mv_o), (c == 31) ? 16'd800 : 16'(c * 25));
      check("R3 code out", 16'(offs_code_o), 16'(c));
    end

    // R7 / R8: pulse timing and its effect
    wr(8'h00, 8'h0A);
    wr(8'h03, 8'h01);
    hi_n = 0;
    while (wd_rst_n_o && hi_n < 1000) begin hi_n++; @(negedge clk); end
    check("R7 high phase", 16'(hi_n), 16'(WAIT_CYC));
    lo_n = 0;
    while (!wd_rst_n_o && lo_n < 1000) begin lo_n++; @(negedge clk); end
    check("R7 low phase", 16'(lo_n), 16'(PULSE_CYC));
    check("R8 offset cleared", 16'(offs_code_o), 16'd0);
    rd_chk("R8 misc flags", 8'h03, 8'h03);
    rd_chk("R8 offset reg", 8'h00, 8'h00);
    wr(8'h03, 8'h01);
    rd_chk("R6 clear wd flag", 8'h03, 8'h01);
    wr(8'h03, 8'h00);
    lo_n = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (!wd_rst_n_o) lo_n++; end
    check("R7 disabled idle", 16'(lo_n), 16'd0);

    // R9: socket reset restores everything
    wr(8'h00, 8'h07);
    wr(8'h03, 8'h01);
    @(negedge clk); socket_i = 1'b1;
    @(negedge clk); socket_i = 1'b0;
    check("R9 offset out", 16'(offs_code_o), 16'd0);
    check("R9 wd high", 16'(wd_rst_n_o), 16'd1);
    rd_chk("R9 misc default", 8'h03, 8'h04);
    rd_chk("R9 offset reg", 8'h00, 8'h00);
    lo_n = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (!wd_rst_n_o) lo_n++; end
    check("R9 generator stopped", 16'(lo_n), 16'd0);

    // R8: watchdog pulse keeps socket flag and enable
    wr(8'h03, 8'h05);
    wr(8'h00, 8'h09);
    hi_n = 0;
    while (wd_rst_n_o && hi_n < 1000) begin hi_n++; @(negedge clk); end
    lo_n = 0;
    while (!wd_rst_n_o && lo_n < 1000) begin lo_n++; @(negedge clk); end
    check("R8 offset out", 16'(offs_code_o), 16'd0);
    rd_chk("R8 misc kept", 8'h03, 8'h07);
    rd_chk("R5 current after pulse", 8'h01, 8'h35);
    wr(8'h03, 8'h00);
    rd_chk("R6 all cleared", 8'h03, 8'h00);

    // R1: other address select value
    addr_sel_i = 1'b1;
    rd_chk("R1 alt address", 8'h03, 8'h00);
    bus_op(1'b0, 1'b1, 7'h2E, 8'h03, 8'h00, a, r);
    check("R1 old address", 16'(a), 16'd0);

    // R2: reset in mid run
    wr(8'h00, 8'h11);
    do_reset();
    check("R2 offset after reset", 16'(offs_code_o), 16'd0);
    rd_chk("R2 misc after reset", 8'h03, 8'h04);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule